// File: doc/BRIEF.md
# Fixed-Priority Shared Bus Arbiter

This block is the central arbiter for a bus shared by several masters. Every master has a dedicated request input and a dedicated grant output. The arbiter selects the highest-priority requester, where a lower master index means higher priority. It keeps the grant with the present owner until a handover is needed. To hand over, it withdraws the grant, waits until the shared bus-busy line is seen idle, and leaves one clock with no grant at all. Only then does it give the bus to the new master.

A locked read-modify-write sequence that the owner flags with the lock input is protected. No handover, preemption included, is started while lock is high, unless the lock-end input marks the final write of that sequence in the same clock. When nobody requests, the grant stays parked on the last owner. After reset the grant is parked on master 0. A handover decision takes effect on the next clock edge. A system that wants the owner to stop after its present transfer therefore drops that master's request one clock before the edge that carries the transfer's final acknowledge.

The controller has three named states. OWN drives a grant to the owner. RELEASE drives no grant and waits for the bus to go idle. GAP is the idle clock between owners. Its transitions are: OWN→RELEASE on an allowed handover, RELEASE→GAP when bus-busy is sampled low, and GAP→OWN on every clock. At the GAP→OWN edge the owner becomes the highest requester at that moment. If no master requests then, the previous owner is kept.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, the grant vector is 0001 (bit 0 = master 0), and the controller is in OWN with owner 0.
- R2: At most one bit of the grant vector is 1 in any cycle.
- R3: When several masters request together, the one with the lowest index is the next owner.
- R4: While lock is 1 and lock-end is 0, the grant vector does not change, even if other masters, including higher-priority ones, are requesting.
- R5: A clock edge that samples lock-end at 1 allows a handover, even with lock at 1. The grant is withdrawn after that edge if a different master is the highest requester.
- R6: A handover is needed when some master requests and the highest requester differs from the owner. This covers both preemption by a higher-priority master and a waiting master after the owner stops requesting. When a handover is allowed, all grants are 0 right after the edge that sampled the request pattern.
- R7: After a grant is withdrawn, the grant vector stays 0 for as long as bus-busy is sampled 1.
- R8: After bus-busy is first sampled 0 with no grant out, exactly one more clock passes with all grants 0. The new grant appears after the following edge.
- R9: When no master requests, or only the owner requests, the grant stays on the owner.
- R10: If no master requests at the end of the idle clock, the grant returns to the previous owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | One request line per master, bit i = master i |
| bus_busy_i | input | 1 | Shared bus-busy line, 1 while a transfer is in progress |
| lock_i | input | 1 | Owner is inside a locked read-modify-write sequence |
| lock_end_i | input | 1 | Owner is on the final write of a locked sequence |
| grant_o | output | N_MASTERS | One grant line per master, bit i = master i |

## Verification
The grant outputs are decoded from registered state only. A handover decision therefore shows as an all-zero grant right after the edge that sampled the request pattern. With bus-busy low, the new owner's grant appears two edges after that. Each extra busy clock adds one more edge. The bench changes inputs on the falling edge, advances one rising edge per step, and compares the grant vector at the next falling edge. This puts every expected value at a known step count. The sweep visits every owner against all sixteen request patterns of the four-master configuration, then drives the lock, lock-end, busy-stall and vanished-request sequences.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_OWN     = 2'd0,
        ST_RELEASE = 2'd1,
        ST_GAP     = 2'd2
    } arb_state_e;

endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
module arb_prio_pick #(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req_i,
    output logic                 valid_o,
    output logic [IDX_W-1:0]     idx_o
);

    logic [N_MASTERS-1:0] lower_any;
    logic [N_MASTERS-1:0] first_hot;

    // lower_any[i] is 1 when any master below i is requesting
    generate
        for (genvar g = 0; g < N_MASTERS; g++) begin : g_chain
            if (g == 0) begin : g_base
                assign lower_any[g] = 1'b0;
            end else begin : g_link
                assign lower_any[g] = lower_any[g-1] | req_i[g-1];
            end
            assign first_hot[g] = req_i[g] & ~lower_any[g];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (first_hot[i]) idx_o = IDX_W'(i);
        end
    end

    assign valid_o = |req_i;

    always_comb begin
        if (valid_o) begin
            a_pick_onehot_r3: assert ($onehot(first_hot));
            a_pick_lowest_r3: assert (req_i[idx_o] && ((req_i & ((N_MASTERS'(1) << idx_o) - N_MASTERS'(1))) == '0));
        end
    end

endmodule

// File: rtl/arb_handover_fsm.sv
// Ownership state machine: OWN -> RELEASE -> GAP -> OWN.
module arb_handover_fsm
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid_i,
    input  logic [IDX_W-1:0] win_idx_i,
    input  logic             bus_busy_i,
    input  logic             lock_i,
    input  logic             lock_end_i,
    output logic             grant_en_o,
    output logic [IDX_W-1:0] owner_o
);

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic             lock_hold;
    logic             handover;

    assign lock_hold = lock_i & ~lock_end_i;
    assign handover  = win_valid_i && (win_idx_i != owner_q) && !lock_hold;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OWN;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_OWN: begin
                if (handover) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!bus_busy_i) state_d = ST_GAP;
            end
            ST_GAP: begin
                state_d = ST_OWN;
                if (win_valid_i) owner_d = win_idx_i;
            end
            default: begin
                state_d = ST_OWN;
            end
        endcase
    end

    // Outputs
    always_comb begin
        grant_en_o = 1'b0;
        unique case (state_q)
            ST_OWN:     grant_en_o = 1'b1;
            ST_RELEASE: grant_en_o = 1'b0;
            ST_GAP:     grant_en_o = 1'b0;
            default:    grant_en_o = 1'b0;
        endcase
    end

    assign owner_o = owner_q;

    p_drop_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && handover) |=> !grant_en_o);

    p_busy_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && bus_busy_i) |=> (state_q == ST_RELEASE));

    p_owner_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && lock_hold) |=> (state_q == ST_OWN && $stable(owner_q)));

endmodule

// File: rtl/arb_grant_drive.sv
// Decodes the owner index into one grant line per master.
module arb_grant_drive #(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 en_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [N_MASTERS-1:0] grant_o
);

    generate
        for (genvar g = 0; g < N_MASTERS; g++) begin : g_line
            assign grant_o[g] = en_i && (idx_i == IDX_W'(g));
        end
    endgenerate

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 bus_busy_i,
    input  logic                 lock_i,
    input  logic                 lock_end_i,
    output logic [N_MASTERS-1:0] grant_o
);

    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic             grant_en;
    logic [IDX_W-1:0] owner;

    arb_prio_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
        .req_i   (req_i),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    arb_handover_fsm #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid_i (win_valid),
        .win_idx_i   (win_idx),
        .bus_busy_i  (bus_busy_i),
        .lock_i      (lock_i),
        .lock_end_i  (lock_end_i),
        .grant_en_o  (grant_en),
        .owner_o     (owner)
    );

    arb_grant_drive #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_drive (
        .en_i    (grant_en),
        .idx_i   (owner),
        .grant_o (grant_o)
    );

    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_lock_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !lock_end_i && grant_o != '0) |=> (grant_o == $past(grant_o)));

    p_idle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && $past(grant_o) == '0) |->
            ($past(bus_busy_i, 2) == 1'b0 && $past(grant_o, 2) == '0));

    p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && (req_i & ~grant_o) == '0) |=> (grant_o == $past(grant_o)));

endmodule

// File: tb/prio_bus_arbiter_tb.sv
module prio_bus_arbiter_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         busy = 1'b0;
    logic         lock = 1'b0;
    logic         lock_end = 1'b0;
    logic [N-1:0] grant;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    prio_bus_arbiter #(.N_MASTERS(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .bus_busy_i (busy),
        .lock_i     (lock),
        .lock_end_i (lock_end),
        .grant_o    (grant)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [N-1:0] exp);
        n_checks++;
        if (grant !== exp) begin
            n_fail++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp);
        end
    endtask

    function automatic int low_bit(input logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) low_bit = i;
        end
        if (v == '0) low_bit = -1;
    endfunction

    // Hand the bus to master m through a full idle handover.
    task automatic move_to(input int m, inout int own);
        if (own != m) begin
            req  = N'(1) << m;
            busy = 1'b0;
            step(); check("R6 drop on move", '0);
            step(); check("R8 idle clock on move", '0);
            step(); check("R3 new owner on move", N'(1) << m);
            req = '0;
            own = m;
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog grant actual=%b expected=finished", grant);
                    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        int own;
        @(negedge clk);
        check("R1 during reset", 4'b0001);
        step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 4'b0001);
        own = 0;

        // R9: parking with no requests
        step(); step();
        check("R9 park no request", 4'b0001);

        // Exhaustive owner x request pattern sweep: R3, R6, R7, R8, R9
        for (int o = 0; o < N; o++) begin
            for (int p = 0; p < (1 << N); p++) begin
                int w;
                move_to(o, own);
                w    = low_bit(N'(p));
                busy = 1'b1;
                req  = N'(p);
                step();
                if (w < 0 || w == o) begin
                    check("R9 stay with owner", N'(1) << o);
                end else begin
                    check("R6 grant withdrawn", '0);
                    step(); check("R7 busy holds off", '0);
                    busy = 1'b0;
                    step(); check("R8 idle clock", '0);
                    step(); check("R3 lowest index wins", N'(1) << w);
                    own = w;
                end
                busy = 1'b0;
                req  = '0;
            end
        end

        // R4 / R5: lock blocks a handover until lock-end
        move_to(2, own);
        lock = 1'b1;
        req  = 4'b0011;
        for (int k = 0; k < 4; k++) begin
            step(); check("R4 lock holds grant", 4'b0100);
        end
        lock_end = 1'b1;
        step(); check("R5 lock-end releases", '0);
        lock_end = 1'b0;
        lock     = 1'b0;
        step(); check("R8 idle clock after lock", '0);
        step(); check("R3 after lock", 4'b0001);
        own = 0;

        // R5: back-to-back locked sequences, lock stays high across lock-end
        req  = '0;
        move_to(1, own);
        lock = 1'b1;
        req  = 4'b1000;
        step(); check("R4 back-to-back hold", 4'b0010);
        lock_end = 1'b1;
        step(); check("R5 back-to-back release", '0);
        lock_end = 1'b0;
        step(); check("R8 back-to-back idle", '0);
        step(); check("R3 back-to-back owner", 4'b1000);
        lock = 1'b0;
        own  = 3;

        // R7: long busy stall
        req  = 4'b0100;
        busy = 1'b1;
        step(); check("R6 drop before stall", '0);
        for (int k = 0; k < 5; k++) begin
            step(); check("R7 long stall", '0);
        end
        busy = 1'b0;
        step(); check("R8 idle after stall", '0);
        step(); check("R3 after stall", 4'b0100);
        own = 2;

        // R10: requests vanish during the idle clock
        req = 4'b0001;
        step(); check("R6 drop before vanish", '0);
        step(); check("R8 idle before vanish", '0);
        req = '0;
        step(); check("R10 previous owner kept", 4'b0100);
        step(); check("R9 park after vanish", 4'b0100);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule